// File: doc/BRIEF.md
# Page-Mode DRAM Controller with CAS-before-RAS Refresh

This block connects a simple processor-side request port to an asynchronous DRAM whose address pins are shared between row and column. It takes a read or write strobe together with a flat address. The upper address bits go out as the row when RAS# falls, and the lower bits go out as the column when CAS# falls. The controller also produces the WE# and OE# strobes and drives the write data. Each timing limit (row-to-column delay, read latency, precharge time, minimum row-active time) is a count of clock cycles set by a parameter.

The controller keeps the last activated row open. When the next access falls in that same row, only a new CAS# cycle is run. When it falls in a different row, the open row is closed, the precharge time is waited out, and the new row is opened. A free-running interval timer requests a CAS-before-RAS refresh. That refresh has priority over new processor requests, and any access already accepted is completed first. The processor sees `cpu_ready` high only when a new strobe can be accepted and the last read result on `cpu_rdata` is valid.

Top module: `dram_ctrl`

## Requirements
- R1: During and right after reset, RAS#, CAS#, WE# and OE# are high, the data bus driver is off, and `cpu_ready` is high.
- R2: When RAS# falls for an access, `dram_addr` carries address bits [ROW_W+COL_W-1:COL_W]. When CAS# falls, `dram_addr` carries bits [COL_W-1:0], zero-extended.
- R3: CAS# never falls while RAS# is low unless RAS# has been low for at least T_RCD cycles.
- R4: Read data is sampled at the end of the T_CL-th cycle with CAS# low, and `cpu_ready` stays low while CAS# is low. A strobe accepted from the idle state completes after T_RCD+T_CL+1 cycles. A strobe that hits the open row completes after T_CL+1 cycles.
- R5: RAS# falls only after it has been high for at least T_RP cycles.
- R6: RAS# rises only after it has been low for at least T_RAS cycles.
- R7: An access to the row that is already open keeps RAS# low and runs only a CAS# cycle, with no new activation.
- R8: An access to a different row closes the open row, precharges, and performs exactly one new activation.
- R9: For a write, WE# is low and the data driver is enabled only while CAS# is low, and the written value is read back later.
- R10: A refresh lowers CAS# at least one cycle before RAS#, with WE# high. Consecutive refreshes are at most REF_INTERVAL plus a bounded service delay apart.
- R11: Refresh takes priority over new requests. Once the interval expires, no further strobe is accepted until the refresh has run, so refresh is never starved under continuous traffic.
- R12: A strobe presented while `cpu_ready` is low is ignored and has no effect on the memory.
- R13: WE# and OE# are never low together. For a read, OE# is low during the CAS# cycle and WE# stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | ROW_W+COL_W | Flat request address |
| cpu_wdata | input | DW | Write data |
| cpu_rd | input | 1 | Read strobe, taken when `cpu_ready` is high |
| cpu_wr | input | 1 | Write strobe, taken when `cpu_ready` is high |
| cpu_ready | output | 1 | Controller can accept a strobe; last read result valid |
| cpu_rdata | output | DW | Last read result |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DW | Data driven towards memory |
| dram_dq_oe | output | 1 | Enable for the data driver |
| dram_dq_in | input | DW | Data returned by memory |

## Verification
Two events can land in the same cycle: the refresh interval expiring, and a processor strobe being accepted or a page-miss close being in progress. The bench issues long runs of back-to-back random accesses, with about half of them staying in the open row, so that expiries keep falling on busy cycles. It then judges the result by the spacing between observed CAS-before-RAS events, by the strobe order at every refresh, and by whether every read still matches a reference copy of memory. The memory model returns valid data only after CAS# has been low for T_CL cycles, so a capture made too early shows up as wrong data.

// File: rtl/dramc_pkg.sv
// Package for the DRAM controller: the sequencer state type and a helper
// that tells which states hold the row strobe low.
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // no row open, all strobes high
        ST_ACT,      // row strobe low, row address out
        ST_COL,      // column strobe low, column address out
        ST_OPEN,     // row held open, waiting for a request
        ST_CLOSE,    // row must close, waiting for minimum active time
        ST_PRE,      // precharge, all strobes high
        ST_REF_CAS,  // refresh: column strobe leads
        ST_REF_RAS   // refresh: both strobes low
    } dram_state_e;

    // True for the states in which the row strobe is asserted.
    function automatic logic ras_active(dram_state_e s);
        return (s == ST_ACT) || (s == ST_COL) || (s == ST_OPEN) ||
               (s == ST_CLOSE) || (s == ST_REF_RAS);
    endfunction

endpackage

// File: rtl/dramc_refresh_timer.sv
// Free-running refresh interval timer. Raises pend once every INTERVAL
// cycles and holds it until the sequencer acknowledges that a refresh has
// started. An expiry that coincides with the acknowledge keeps pend set.
// Assumes INTERVAL >= 2.
module dramc_refresh_timer #(
    parameter int INTERVAL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(INTERVAL - 1));

    // Count the interval and keep the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/dramc_ras_guard.sv
// Tracks how long the row strobe has been low. ok goes high in the cycle
// after which the row has been active for T_RAS cycles, so the strobe may
// rise at the next edge. Assumes ras_low is a registered state decode.
module dramc_ras_guard #(
    parameter int T_RAS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic ok
);
    generate
        if (T_RAS <= 1) begin : g_free
            assign ok = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(T_RAS + 1);
            logic [CW-1:0] cnt;

            // Count active cycles, saturating at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n || !ras_low)
                    cnt <= '0;
                else if (cnt != CW'(T_RAS))
                    cnt <= cnt + 1'b1;
            end

            assign ok = ras_low && (cnt >= CW'(T_RAS - 1));
        end
    endgenerate
endmodule

// File: rtl/dramc_addr_mux.sv
// Splits the flat address into row (upper bits) and column (lower bits)
// and selects one of them, zero-extended, onto the shared address pins.
module dramc_addr_mux #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int MAW   = 4
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic                   sel_col,
    output logic [MAW-1:0]         pins
);
    logic [MAW-1:0] row_ext, col_ext;

    assign row_ext = MAW'(addr[ROW_W+COL_W-1:COL_W]);
    assign col_ext = MAW'(addr[COL_W-1:0]);

    // Drive the column during column cycles, the row otherwise.
    always_comb pins = sel_col ? col_ext : row_ext;
endmodule

// File: rtl/dram_ctrl.sv
// Asynchronous DRAM controller with page mode and CAS-before-RAS refresh.
// One sequencer handles activation, column cycles, precharge and refresh.
// All timing limits are cycle counts. Assumes T_RCD, T_CL, T_RP, T_RAS
// are at least 1 and that the memory settles read data within a cycle.
module dram_ctrl #(
    parameter int ROW_W        = 4,
    parameter int COL_W        = 4,
    parameter int DW           = 8,
    parameter int T_RCD        = 2,
    parameter int T_CL         = 2,
    parameter int T_RP         = 2,
    parameter int T_RAS        = 5,
    parameter int REF_INTERVAL = 200,
    localparam int AW  = ROW_W + COL_W,
    localparam int MAW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    input  logic           cpu_rd,
    input  logic           cpu_wr,
    output logic           cpu_ready,
    output logic [DW-1:0]  cpu_rdata,
    output logic [MAW-1:0] dram_addr,
    output logic           dram_ras_n,
    output logic           dram_cas_n,
    output logic           dram_we_n,
    output logic           dram_oe_n,
    output logic [DW-1:0]  dram_dq_out,
    output logic           dram_dq_oe,
    input  logic [DW-1:0]  dram_dq_in
);
    import dramc_pkg::*;

    localparam int TMAX  = (T_RCD > T_CL ? (T_RCD > T_RP ? (T_RCD > T_RAS ? T_RCD : T_RAS)
                                                         : (T_RP > T_RAS ? T_RP : T_RAS))
                                         : (T_CL > T_RP ? (T_CL > T_RAS ? T_CL : T_RAS)
                                                        : (T_RP > T_RAS ? T_RP : T_RAS)));
    localparam int TMR_W = $clog2(TMAX + 1);

    dram_state_e      state, state_nxt;
    logic [TMR_W-1:0] tmr, tmr_load;
    logic             ref_pend, ref_ack, ras_ok;
    logic             accept, hit, tmr_done, col_last;
    logic             row_valid, req_live, req_wr;
    logic [AW-1:0]    req_addr;
    logic [DW-1:0]    req_wdata, rdata_q;
    logic [ROW_W-1:0] open_row;

    dramc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
    );

    dramc_ras_guard #(.T_RAS(T_RAS)) u_guard (
        .clk(clk), .rst_n(rst_n), .ras_low(ras_active(state)), .ok(ras_ok)
    );

    dramc_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MAW(MAW)) u_amux (
        .addr(req_addr), .sel_col(state == ST_COL), .pins(dram_addr)
    );

    assign cpu_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_pend;
    assign accept    = cpu_ready && (cpu_rd || cpu_wr);
    assign hit       = row_valid && (cpu_addr[AW-1:COL_W] == open_row);
    assign tmr_done  = (tmr == '0);
    assign col_last  = (state == ST_COL) && tmr_done;
    assign ref_ack   = (state_nxt == ST_REF_CAS) && (state != ST_REF_CAS);

    // Next-state choice of the sequencer.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (ref_pend) state_nxt = ST_REF_CAS;
                        else if (accept) state_nxt = ST_ACT;
            ST_ACT:     if (tmr_done) state_nxt = ST_COL;
            ST_COL:     if (tmr_done) state_nxt = ST_OPEN;
            ST_OPEN:    if (ref_pend || (accept && !hit))
                            state_nxt = ras_ok ? ST_PRE : ST_CLOSE;
                        else if (accept) state_nxt = ST_COL;
            ST_CLOSE:   if (ras_ok) state_nxt = ST_PRE;
            ST_PRE:     if (tmr_done) begin
                            if (req_live)      state_nxt = ST_ACT;
                            else if (ref_pend) state_nxt = ST_REF_CAS;
                            else               state_nxt = ST_IDLE;
                        end
            ST_REF_CAS: state_nxt = ST_REF_RAS;
            ST_REF_RAS: if (tmr_done) state_nxt = ST_PRE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // Cycle count each state must last, loaded on entry.
    always_comb begin
        unique case (state_nxt)
            ST_ACT:     tmr_load = TMR_W'(T_RCD - 1);
            ST_COL:     tmr_load = TMR_W'(T_CL - 1);
            ST_PRE:     tmr_load = TMR_W'(T_RP - 1);
            ST_REF_RAS: tmr_load = TMR_W'(T_RAS - 1);
            default:    tmr_load = '0;
        endcase
    end

    // State register and the shared state timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt != state) tmr <= tmr_load;
            else if (!tmr_done)     tmr <= tmr - 1'b1;
        end
    end

    // Latch an accepted request and track it until its column cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_live  <= 1'b0;
            req_wr    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else if (accept) begin
            req_live  <= 1'b1;
            req_wr    <= cpu_wr;
            req_addr  <= cpu_addr;
            req_wdata <= cpu_wdata;
        end else if (col_last) begin
            req_live  <= 1'b0;
        end
    end

    // Remember which row is open for page-hit detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_valid <= 1'b0;
            open_row  <= '0;
        end else if (state == ST_ACT) begin
            row_valid <= 1'b1;
            open_row  <= req_addr[AW-1:COL_W];
        end else if (state == ST_PRE) begin
            row_valid <= 1'b0;
        end
    end

    // Capture read data at the end of the last column cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (col_last && !req_wr) rdata_q <= dram_dq_in;
    end

    assign cpu_rdata   = rdata_q;
    assign dram_ras_n  = !ras_active(state);
    assign dram_cas_n  = !((state == ST_COL) || (state == ST_REF_CAS) || (state == ST_REF_RAS));
    assign dram_we_n   = !((state == ST_COL) && req_wr);
    assign dram_oe_n   = !((state == ST_COL) && !req_wr);
    assign dram_dq_oe  = (state == ST_COL) && req_wr;
    assign dram_dq_out = req_wdata;
endmodule

// File: rtl/dram_ctrl_chk.sv
// Protocol checker for dram_ctrl, watching only its pins. Counts how long
// the row strobe has been high or low so the cycle limits can be checked
// for any parameter value.
module dram_ctrl_chk #(
    parameter int T_RCD = 2,
    parameter int T_RP  = 2,
    parameter int T_RAS = 5
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic cpu_ready
);
    logic [15:0] low_cnt, high_cnt;

    // Count consecutive low and high cycles of the row strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= 16'(T_RP);
        end else if (!ras_n) begin
            high_cnt <= '0;
            if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
            if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 1'b1;
        end
    end

    AST_RCD_MET:   assert property (@(posedge clk) disable iff (!rst_n) $fell(cas_n) && !ras_n |-> low_cnt >= 16'(T_RCD)); // R3
    AST_HOLD_OFF:  assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !cpu_ready); // R4
    AST_RP_MET:    assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> high_cnt >= 16'(T_RP)); // R5
    AST_RAS_MET:   assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> low_cnt >= 16'(T_RAS)); // R6
    AST_DQ_DRIVE:  assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> !we_n && !cas_n); // R9
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) && !cas_n |-> !$past(cas_n)); // R10
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !oe_n)); // R13
endmodule

bind dram_ctrl dram_ctrl_chk #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .cpu_ready(cpu_ready)
);

// File: tb/dram_ctrl_tb.sv
module dram_ctrl_tb;
    localparam int ROW_W = 4, COL_W = 4, DW = 8;
    localparam int T_RCD = 2, T_CL = 2, T_RP = 2, T_RAS = 5, REF_INTERVAL = 64;
    localparam int AW = ROW_W + COL_W, MAW = 4;
    localparam int SLACK = 2*T_RAS + 2*T_RP + T_RCD + T_CL + 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata, dram_dq_out, dram_dq_in;
    logic cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_ready;
    logic [MAW-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

    always #2.5 clk = ~clk;

    dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD), .T_CL(T_CL),
                .T_RP(T_RP), .T_RAS(T_RAS), .REF_INTERVAL(REF_INTERVAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0, errors = 0;
    logic [DW-1:0] mem     [0:(1<<AW)-1];
    logic [DW-1:0] ref_mem [0:(1<<AW)-1];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] seed_val(input int i);
        return DW'(i * 37 + 11);
    endfunction

    // ---------------- memory model ----------------
    logic [ROW_W-1:0] m_row = '0;
    int  cas_cnt = 0, low_cnt = 0, high_cnt = T_RP, cyc = 0;
    int  ras_falls = 0, refreshes = 0, last_ref = 0;
    bit  prev_ras = 1'b1, prev_cas = 1'b1, model_on = 1'b0;
    logic [AW-1:0] cur_addr = '0;
    bit  cur_wr = 1'b0;

    assign dram_dq_in = (!dram_cas_n && !dram_oe_n && cas_cnt >= T_CL)
                        ? mem[{m_row, dram_addr[COL_W-1:0]}]
                        : ~mem[{m_row, dram_addr[COL_W-1:0]}];

    always @(negedge clk) begin
        if (model_on) begin
            cyc++;
            if (!dram_ras_n && prev_ras) begin
                ras_falls++;
                check(high_cnt >= T_RP, "R5", high_cnt, T_RP);
                if (!dram_cas_n) begin
                    refreshes++;
                    check(!prev_cas, "R10 cas leads ras", 0, 1);
                    check(dram_we_n, "R10 we high", 0, 1);
                    check(cyc - last_ref <= REF_INTERVAL + SLACK, "R11 refresh gap",
                          cyc - last_ref, REF_INTERVAL + SLACK);
                    last_ref = cyc;
                end else begin
                    m_row = dram_addr[ROW_W-1:0];
                    check(m_row == cur_addr[AW-1:COL_W], "R2 row", m_row, cur_addr[AW-1:COL_W]);
                end
            end
            if (dram_ras_n && !prev_ras)
                check(low_cnt >= T_RAS, "R6", low_cnt, T_RAS);
            if (!dram_cas_n && prev_cas && !dram_ras_n) begin
                check(low_cnt >= T_RCD, "R3", low_cnt, T_RCD);
                check(dram_addr == MAW'(cur_addr[COL_W-1:0]), "R2 col", dram_addr, cur_addr[COL_W-1:0]);
                check(dram_we_n == !cur_wr && dram_oe_n == cur_wr && dram_dq_oe == cur_wr,
                      "R13/R9 strobes", {dram_we_n, dram_oe_n, dram_dq_oe}, {!cur_wr, cur_wr, cur_wr});
            end
            if (!dram_ras_n && !dram_cas_n && !dram_we_n)
                mem[{m_row, dram_addr[COL_W-1:0]}] = dram_dq_out;
            if (!dram_cas_n) cas_cnt++; else cas_cnt = 0;
            if (!dram_ras_n) begin low_cnt++; high_cnt = 0; end
            else begin high_cnt++; low_cnt = 0; end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    // ---------------- CPU side ----------------
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int lat);
        while (!cpu_ready) @(negedge clk);
        cur_addr = a; cur_wr = wr;
        cpu_addr = a; cpu_wdata = d; cpu_rd = !wr; cpu_wr = wr;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        lat = 1;
        while (!cpu_ready) begin @(negedge clk); lat++; end
        if (wr) ref_mem[a] = d;
        else check(cpu_rdata == ref_mem[a], "R4 read data", cpu_rdata, ref_mem[a]);
    endtask

    function automatic int cpu_acts();
        return ras_falls - refreshes;
    endfunction

    initial begin : wd
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int lat, r0, a0, rf;
        logic [AW-1:0] a, last_a;
        for (int i = 0; i < (1 << AW); i++) begin
            mem[i] = seed_val(i); ref_mem[i] = seed_val(i);
        end
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF && !dram_dq_oe,
              "R1 strobes in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        rst_n = 1'b1; model_on = 1'b1;
        @(negedge clk);
        check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF && !dram_dq_oe,
              "R1 strobes after reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        check(cpu_ready, "R1 ready", cpu_ready, 1);

        // Read from idle just after a refresh.
        while (refreshes < 1) @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        r0 = refreshes; a0 = cpu_acts();
        access(1'b0, 8'h35, '0, lat);
        if (refreshes == r0) check(lat == T_RCD + T_CL + 1, "R4 idle latency", lat, T_RCD + T_CL + 1);
        check(cpu_acts() == a0 + 1, "R8 one activation", cpu_acts() - a0, 1);

        // Page hit read.
        r0 = refreshes; a0 = cpu_acts();
        access(1'b0, 8'h3A, '0, lat);
        if (refreshes == r0) begin
            check(lat == T_CL + 1, "R4 hit latency", lat, T_CL + 1);
            check(cpu_acts() == a0, "R7 no activation", cpu_acts() - a0, 0);
        end

        // Write in the open row, then read back.
        access(1'b1, 8'h39, 8'hC3, lat);
        access(1'b0, 8'h39, '0, lat);
        check(cpu_rdata == 8'hC3, "R9 write readback", cpu_rdata, 8'hC3);

        // Page miss.
        r0 = refreshes; a0 = cpu_acts();
        access(1'b0, 8'h72, '0, lat);
        if (refreshes == r0) check(cpu_acts() == a0 + 1, "R8 miss reopens", cpu_acts() - a0, 1);

        // Strobe during busy cycle must be ignored.
        while (!cpu_ready) @(negedge clk);
        cur_addr = 8'h74; cur_wr = 1'b1;
        cpu_addr = 8'h74; cpu_wdata = 8'h5E; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_addr = 8'hE1; cpu_wdata = 8'h99; cpu_wr = 1'b1;
        check(!cpu_ready, "R12 busy", cpu_ready, 0);
        @(negedge clk);
        cpu_wr = 1'b0;
        while (!cpu_ready) @(negedge clk);
        ref_mem[8'h74] = 8'h5E;
        access(1'b0, 8'hE1, '0, lat);
        check(cpu_rdata == seed_val(8'hE1), "R12 ignored write", cpu_rdata, seed_val(8'hE1));
        access(1'b0, 8'h74, '0, lat);

        // Random traffic, half in the open row.
        last_a = 8'h74;
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 2) a = {last_a[AW-1:COL_W], COL_W'($urandom)};
            else a = AW'($urandom);
            access(bit'($urandom % 2), a, DW'($urandom), lat);
            last_a = a;
        end

        // Idle period: refresh keeps running.
        rf = refreshes;
        repeat (3 * REF_INTERVAL) @(negedge clk);
        check(refreshes - rf >= 2, "R10 idle refreshes", refreshes - rf, 2);
        check(cyc - last_ref <= REF_INTERVAL + SLACK, "R10 final gap", cyc - last_ref, REF_INTERVAL + SLACK);

        // Final sweep: every location matches the reference.
        for (int i = 0; i < (1 << AW); i += 7) access(1'b0, AW'(i), '0, lat);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule